// File: doc/BRIEF.md
# Radix Page Table Walker

This block resolves a translation miss by reading a radix page table tree held in memory. It accepts the missing virtual page number, the frame number of the table to start from, and the level to start at. From there it descends one level per memory read. Each read goes out through a simple valid/ready request port, and each answer returns on a response port. The walker decodes every returned entry and either follows it to the next table or stops with a result.

A walk ends in one of three ways. The last-level table supplies a small-page frame. An intermediate entry marked as a large-page leaf ends the walk early, and the walker then merges the low virtual page bits into the returned frame. An entry whose present bit is clear ends the walk with a fault. A walk that ends with a frame produces a one-cycle refill pulse towards the translation buffer, carrying the frame and a page-size code. A fault produces a separate one-cycle pulse that reports the level at which the walk stopped. Only one walk runs at a time.

A caller that already holds a cached upper-level entry can skip the upper reads. It passes that entry's frame as the root and names the level at which the walk should begin.

Top module: `pt_walker`

## Requirements
- R1: The table at level L (0 = top, 3 = last) is indexed by VPN bits [(3-L)*IDX_W +: IDX_W]. The read address is {table frame, 12 zero bits} + 8 × index, so its bits [2:0] are always zero.
- R2: Levels are visited strictly from the start level downwards, with exactly one memory read per visited level. No walk issues more than four reads.
- R3: At level 1, an entry with bit 0 set and bit 7 set is a large leaf. fill_size is 2. fill_pfn takes entry bits [51:12] with its low 2*IDX_W bits replaced by the low 2*IDX_W VPN bits.
- R4: At level 2, an entry with bit 0 set and bit 7 set is a leaf. fill_size is 1. The low IDX_W bits of fill_pfn come from the VPN and the rest from entry bits [51:12].
- R5: A present entry at level 3 is always a leaf, with fill_size 0 and fill_pfn equal to entry bits [51:12]. Bit 7 has no effect at level 0 or level 3, and a present entry at level 0 always points to the next table.
- R6: An entry with bit 0 clear at any level ends the walk. fault_valid pulses, fault_level gives that level, and fill_valid stays low.
- R7: miss_start selects the first level read. The first read uses miss_root as the table frame.
- R8: A miss is accepted only while walk_idle is high. miss_valid and its fields have no effect while a walk is in progress.
- R9: req_valid with req_addr held stable stays asserted until req_ready is seen. rsp_valid is ignored unless a read has been accepted and not yet answered.
- R10: After reset, walk_idle is high and req_valid, fill_valid and fault_valid are low.
- R11: fill_valid and fault_valid are single-cycle pulses, never high together, and walk_vpn shows the VPN of the finished walk during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | New miss offered |
| miss_vpn | input | LEVELS*IDX_W | Virtual page number to translate |
| miss_root | input | PA_W-12 | Frame of the table the walk starts in |
| miss_start | input | clog2(LEVELS) | Level the walk starts at |
| walk_idle | output | 1 | No walk in progress; a miss can be taken |
| req_valid | output | 1 | Memory read request |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | PA_W | Byte address of the entry read |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Returned table entry |
| fill_valid | output | 1 | Translation found, refill pulse |
| fill_pfn | output | PA_W-12 | Resolved 4 KB-granular frame number |
| fill_size | output | clog2(LEVELS) | Page size code: 0 small, 1 mid, 2 large |
| fault_valid | output | 1 | Walk ended on a non-present entry |
| fault_level | output | clog2(LEVELS) | Level of the non-present entry |
| walk_vpn | output | LEVELS*IDX_W | VPN of the walk just finished |

## Verification
The bench builds the walker with IDX_W = 3 and the other parameters at their defaults. The virtual page number is then only 12 bits wide, so every VPN can be walked from the top level, and a further slice of VPNs is walked from each lower start level. Table entries are generated by an arithmetic hash of their address, which produces faults at every level, large leaves at both middle levels, and stray large-page bits at the top and bottom. The memory model stalls requests, returns data with varying latency, drives junk responses while a request waits, and holds a second miss on the inputs during some walks. Each read address is compared against the expected index path.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Entry bit positions the decoder relies on
    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_LEAF_BIT    = 7;

    // Byte offset inside a 4 KB page and log2 of the entry size
    localparam int PG_SHIFT  = 12;
    localparam int ENT_SHIFT = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_st_e;

endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    localparam int VPN_W = LEVELS * IDX_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx
);

    // One slice per level; level 0 takes the topmost bits
    logic [IDX_W-1:0] slice [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) begin
                idx = slice[i];
            end
        end
    end

endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec
    import ptw_pkg::*;
#(
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PA_W     = 52,
    parameter int PTE_W    = 64,
    parameter int LG_FIRST = 1,
    parameter int LG_LAST  = 2,
    localparam int VPN_W   = LEVELS * IDX_W,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int FRAME_W = PA_W - PG_SHIFT
) (
    input  logic [PTE_W-1:0]   pte,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [VPN_W-1:0]   vpn,
    output logic               present,
    output logic               leaf,
    output logic [FRAME_W-1:0] next_base,
    output logic [FRAME_W-1:0] leaf_pfn,
    output logic [LVL_W-1:0]   size
);

    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] vpn_ext;
    logic [FRAME_W-1:0] keep_m [LEVELS];
    logic [FRAME_W-1:0] sel_m;
    logic               last_lvl;
    logic               large_ok;
    logic               unused_pte_bits;

    assign frame     = pte[PA_W-1:PG_SHIFT];
    assign vpn_ext   = FRAME_W'(vpn);
    assign present   = pte[PTE_PRESENT_BIT];
    assign next_base = frame;

    // Low frame bits that a leaf at each level takes from the VPN
    for (genvar g = 0; g < LEVELS; g++) begin : g_mask
        assign keep_m[g] = (FRAME_W'(1) << ((LEVELS-1-g)*IDX_W)) - FRAME_W'(1);
    end

    always_comb begin
        sel_m = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) begin
                sel_m = keep_m[i];
            end
        end
    end

    assign last_lvl = (lvl == LVL_W'(LEVELS-1));
    assign large_ok = (lvl >= LVL_W'(LG_FIRST)) && (lvl <= LVL_W'(LG_LAST));
    assign leaf     = last_lvl || (large_ok && pte[PTE_LEAF_BIT]);
    assign leaf_pfn = (frame & ~sel_m) | (vpn_ext & sel_m);
    assign size     = LVL_W'(LEVELS-1) - lvl;

    // Attribute bits this walker does not interpret
    assign unused_pte_bits = ^{pte[PTE_W-1:PA_W], pte[PG_SHIFT-1:PTE_LEAF_BIT+1],
                               pte[PTE_LEAF_BIT-1:PTE_PRESENT_BIT+1]};

endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
    import ptw_pkg::*;
#(
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PA_W     = 52,
    localparam int VPN_W   = LEVELS * IDX_W,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int FRAME_W = PA_W - PG_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    // new miss
    input  logic               miss_valid,
    input  logic [VPN_W-1:0]   miss_vpn,
    input  logic [FRAME_W-1:0] miss_root,
    input  logic [LVL_W-1:0]   miss_start,
    output logic               walk_idle,
    // read port handshake
    output logic               req_valid,
    input  logic               req_ready,
    input  logic               rsp_valid,
    // walk context for index selection and decode
    output logic [VPN_W-1:0]   cur_vpn,
    output logic [LVL_W-1:0]   cur_lvl,
    output logic [FRAME_W-1:0] cur_base,
    // decoded entry
    input  logic               dec_present,
    input  logic               dec_leaf,
    input  logic [FRAME_W-1:0] dec_next,
    input  logic [FRAME_W-1:0] dec_pfn,
    input  logic [LVL_W-1:0]   dec_size,
    // results
    output logic               fill_valid,
    output logic [FRAME_W-1:0] fill_pfn,
    output logic [LVL_W-1:0]   fill_size,
    output logic               fault_valid,
    output logic [LVL_W-1:0]   fault_level
);

    typedef struct packed {
        walk_st_e           st;
        logic [VPN_W-1:0]   vpn;
        logic [FRAME_W-1:0] base;
        logic [LVL_W-1:0]   lvl;
        logic               fill;
        logic               fault;
        logic [FRAME_W-1:0] pfn;
        logic [LVL_W-1:0]   size;
        logic [LVL_W-1:0]   flvl;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d       = q;
        d.fill  = 1'b0;
        d.fault = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (miss_valid) begin
                    d.st   = ST_REQ;
                    d.vpn  = miss_vpn;
                    d.base = miss_root;
                    d.lvl  = miss_start;
                end
            end

            ST_REQ: begin
                // address is held by the registered context until taken
                if (req_ready) begin
                    d.st = ST_WAIT;
                end
            end

            ST_WAIT: begin
                if (rsp_valid) begin
                    if (!dec_present) begin
                        d.st    = ST_IDLE;
                        d.fault = 1'b1;
                        d.flvl  = q.lvl;
                    end else if (dec_leaf) begin
                        d.st   = ST_IDLE;
                        d.fill = 1'b1;
                        d.pfn  = dec_pfn;
                        d.size = dec_size;
                    end else begin
                        d.st   = ST_REQ;
                        d.base = dec_next;
                        d.lvl  = q.lvl + LVL_W'(1);
                    end
                end
            end

            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign walk_idle   = (q.st == ST_IDLE);
    assign req_valid   = (q.st == ST_REQ);
    assign cur_vpn     = q.vpn;
    assign cur_lvl     = q.lvl;
    assign cur_base    = q.base;
    assign fill_valid  = q.fill;
    assign fill_pfn    = q.pfn;
    assign fill_size   = q.size;
    assign fault_valid = q.fault;
    assign fault_level = q.flvl;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PA_W     = 52,
    parameter int PTE_W    = 64,
    parameter int LG_FIRST = 1,
    parameter int LG_LAST  = 2,
    localparam int VPN_W   = LEVELS * IDX_W,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int FRAME_W = PA_W - PG_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    input  logic [VPN_W-1:0]   miss_vpn,
    input  logic [FRAME_W-1:0] miss_root,
    input  logic [LVL_W-1:0]   miss_start,
    output logic               walk_idle,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [PA_W-1:0]    req_addr,
    input  logic               rsp_valid,
    input  logic [PTE_W-1:0]   rsp_data,
    output logic               fill_valid,
    output logic [FRAME_W-1:0] fill_pfn,
    output logic [LVL_W-1:0]   fill_size,
    output logic               fault_valid,
    output logic [LVL_W-1:0]   fault_level,
    output logic [VPN_W-1:0]   walk_vpn
);

    logic [VPN_W-1:0]   cur_vpn;
    logic [LVL_W-1:0]   cur_lvl;
    logic [FRAME_W-1:0] cur_base;
    logic [IDX_W-1:0]   cur_idx;
    logic               dec_present;
    logic               dec_leaf;
    logic [FRAME_W-1:0] dec_next;
    logic [FRAME_W-1:0] dec_pfn;
    logic [LVL_W-1:0]   dec_size;

    ptw_seq #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .PA_W   (PA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .miss_vpn    (miss_vpn),
        .miss_root   (miss_root),
        .miss_start  (miss_start),
        .walk_idle   (walk_idle),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .cur_vpn     (cur_vpn),
        .cur_lvl     (cur_lvl),
        .cur_base    (cur_base),
        .dec_present (dec_present),
        .dec_leaf    (dec_leaf),
        .dec_next    (dec_next),
        .dec_pfn     (dec_pfn),
        .dec_size    (dec_size),
        .fill_valid  (fill_valid),
        .fill_pfn    (fill_pfn),
        .fill_size   (fill_size),
        .fault_valid (fault_valid),
        .fault_level (fault_level)
    );

    ptw_idx_sel #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W)
    ) u_idx (
        .vpn (cur_vpn),
        .lvl (cur_lvl),
        .idx (cur_idx)
    );

    ptw_pte_dec #(
        .LEVELS   (LEVELS),
        .IDX_W    (IDX_W),
        .PA_W     (PA_W),
        .PTE_W    (PTE_W),
        .LG_FIRST (LG_FIRST),
        .LG_LAST  (LG_LAST)
    ) u_dec (
        .pte       (rsp_data),
        .lvl       (cur_lvl),
        .vpn       (cur_vpn),
        .present   (dec_present),
        .leaf      (dec_leaf),
        .next_base (dec_next),
        .leaf_pfn  (dec_pfn),
        .size      (dec_size)
    );

    // Entry byte address: table frame in page units plus index times entry size
    assign req_addr = {cur_base, {PG_SHIFT{1'b0}}} + PA_W'({cur_idx, {ENT_SHIFT{1'b0}}});
    assign walk_vpn = cur_vpn;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int LEVELS = 4,
    parameter int PA_W   = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            walk_idle,
    input logic            miss_valid,
    input logic            req_valid,
    input logic            req_ready,
    input logic [PA_W-1:0] req_addr,
    input logic            fill_valid,
    input logic            fault_valid
);

    localparam int CNT_W = $clog2(LEVELS + 2) + 1;

    // Reads issued since the current walk was accepted
    logic [CNT_W-1:0] rd_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
        end else if (walk_idle && miss_valid) begin
            rd_cnt_q <= '0;
        end else if (req_valid && req_ready) begin
            rd_cnt_q <= rd_cnt_q + CNT_W'(1);
        end
    end

    // R2
    read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt_q <= CNT_W'(LEVELS));

    // R1
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[2:0] == 3'b000));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_idle |-> !req_valid);

    // R11
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));

    // R11
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);

    // R6
    fault_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> walk_idle);

endmodule

bind pt_walker pt_walker_chk #(
    .LEVELS (LEVELS),
    .PA_W   (PA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .walk_idle   (walk_idle),
    .miss_valid  (miss_valid),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .fill_valid  (fill_valid),
    .fault_valid (fault_valid)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

    localparam int LEVELS  = 4;
    localparam int IDX_W   = 3;
    localparam int PA_W    = 52;
    localparam int VPN_W   = LEVELS * IDX_W;
    localparam int FRAME_W = PA_W - 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               miss_valid = 1'b0;
    logic [VPN_W-1:0]   miss_vpn = '0;
    logic [FRAME_W-1:0] miss_root = '0;
    logic [1:0]         miss_start = '0;
    logic               walk_idle;
    logic               req_valid;
    logic               req_ready = 1'b0;
    logic [PA_W-1:0]    req_addr;
    logic               rsp_valid = 1'b0;
    logic [63:0]        rsp_data = '0;
    logic               fill_valid;
    logic [FRAME_W-1:0] fill_pfn;
    logic [1:0]         fill_size;
    logic               fault_valid;
    logic [1:0]         fault_level;
    logic [VPN_W-1:0]   walk_vpn;

    always #4 clk = ~clk;   // 125 MHz

    pt_walker #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_vpn(miss_vpn), .miss_root(miss_root),
        .miss_start(miss_start), .walk_idle(walk_idle),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_size(fill_size),
        .fault_valid(fault_valid), .fault_level(fault_level), .walk_vpn(walk_vpn)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    // expected walk
    logic [PA_W-1:0]    exp_addr [4];
    int                 exp_n;
    bit                 exp_fault;
    logic [FRAME_W-1:0] exp_pfn;
    logic [1:0]         exp_size;
    logic [1:0]         exp_flvl;
    // memory model observations
    int                 nreads;
    bit                 addr_err;
    logic [PA_W-1:0]    bad_addr;
    logic [PA_W-1:0]    bad_exp;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mix(input logic [63:0] a);
        logic [63:0] x;
        x = a ^ (a >> 29);
        x = x * 64'h9E3779B97F4A7C15;
        x = x ^ (x >> 32);
        return x;
    endfunction

    // Table content: a hash of the entry address
    function automatic logic [63:0] ent(input logic [PA_W-1:0] addr);
        logic [63:0] h;
        logic        pr;
        logic        ps;
        h  = mix(64'(addr));
        pr = (h[47:45] != 3'd0);
        ps = h[50];
        return {12'h0, h[39:0], 4'h0, ps, 6'h0, pr};
    endfunction

    task automatic compute_exp(input logic [VPN_W-1:0] vpn, input logic [FRAME_W-1:0] root,
                               input int start);
        logic [FRAME_W-1:0] base;
        logic [FRAME_W-1:0] m;
        logic [63:0]        e;
        logic [IDX_W-1:0]   idx;
        bit                 stop;
        base = root;
        exp_n = 0;
        exp_fault = 1'b0;
        exp_pfn = '0;
        exp_size = '0;
        exp_flvl = '0;
        stop = 1'b0;
        for (int l = start; l < LEVELS && !stop; l++) begin
            idx = vpn[(LEVELS-1-l)*IDX_W +: IDX_W];
            exp_addr[exp_n] = {base, 12'h000} + PA_W'(idx) * 8;
            e = ent(exp_addr[exp_n]);
            exp_n++;
            if (!e[0]) begin
                exp_fault = 1'b1;
                exp_flvl = 2'(l);
                stop = 1'b1;
            end else if (l == 3 || (e[7] && (l == 1 || l == 2))) begin
                m = (FRAME_W'(1) << ((3 - l) * IDX_W)) - 1;
                exp_pfn = (e[51:12] & ~m) | (FRAME_W'(vpn) & m);
                exp_size = 2'(3 - l);
                stop = 1'b1;
            end else begin
                base = e[51:12];
            end
        end
    endtask

    // Memory model: stalls requests, variable latency, junk responses while a request waits
    initial begin
        int  stall_ctr = 0;
        bit  pend = 1'b0;
        int  lat = 0;
        logic [PA_W-1:0] paddr = '0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = ent(paddr);
                    pend = 1'b0;
                end else begin
                    lat--;
                end
            end
            req_ready = (stall_ctr % 3 != 1);
            stall_ctr++;
            if (req_valid && req_ready && !pend) begin
                pend  = 1'b1;
                lat   = stall_ctr % 2;
                paddr = req_addr;
                if (nreads >= exp_n || req_addr != exp_addr[nreads]) begin
                    if (!addr_err) begin
                        bad_addr = req_addr;
                        bad_exp  = (nreads < exp_n) ? exp_addr[nreads] : '1;
                    end
                    addr_err = 1'b1;
                end
                nreads++;
            end else if (req_valid && !req_ready && !rsp_valid && !pend) begin
                // R9: response with no accepted request must be ignored
                rsp_valid = 1'b1;
                rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic do_walk(input logic [VPN_W-1:0] vpn, input logic [FRAME_W-1:0] root,
                           input int start, input bit noise);
        int    t = 0;
        string tag;
        compute_exp(vpn, root, start);
        nreads = 0;
        addr_err = 1'b0;
        @(negedge clk);
        while (!walk_idle) @(negedge clk);
        miss_valid = 1'b1;
        miss_vpn   = vpn;
        miss_root  = root;
        miss_start = 2'(start);
        @(negedge clk);
        if (noise) begin
            // R8: a second miss held during the walk must not disturb it
            miss_vpn   = vpn ^ 12'hA5A;
            miss_root  = root ^ 40'h1;
            miss_start = 2'd0;
        end else begin
            miss_valid = 1'b0;
        end
        while (!(fill_valid || fault_valid) && t < 400) begin
            @(negedge clk);
            t++;
        end
        miss_valid = 1'b0;
        if (exp_fault)          tag = "R6 fault";
        else if (exp_size == 2) tag = "R3 level1 leaf";
        else if (exp_size == 1) tag = "R4 level2 leaf";
        else                    tag = "R5 level3 leaf";
        if (start != 0) tag = {tag, " R7 start"};
        if (noise)      tag = {tag, " R8 busy"};
        check(t < 400, {tag, " completion"}, 64'(t), 64'd400);
        if (exp_fault) begin
            check(fault_valid && !fill_valid && fault_level == exp_flvl && walk_vpn == vpn,
                  tag, {fill_valid, fault_valid, 2'(0), fault_level, 16'(walk_vpn)},
                  {1'b0, 1'b1, 2'(0), exp_flvl, 16'(vpn)});
        end else begin
            check(fill_valid && !fault_valid && fill_pfn == exp_pfn && fill_size == exp_size
                  && walk_vpn == vpn,
                  tag, {fill_valid, fault_valid, fill_size, fill_pfn[39:0], 8'h0, 12'(walk_vpn)},
                  {1'b1, 1'b0, exp_size, exp_pfn, 8'h0, 12'(vpn)});
        end
        // R1 R2: every read at the expected address, one per level
        check(!addr_err && nreads == exp_n, "R1 R2 read sequence",
              addr_err ? 64'(bad_addr) : 64'(nreads),
              addr_err ? 64'(bad_exp) : 64'(exp_n));
        @(negedge clk);
        // R11: one-cycle pulse, walker idle again
        check(!fill_valid && !fault_valid && walk_idle, "R11 pulse width",
              {61'h0, fill_valid, fault_valid, walk_idle}, 64'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(walk_idle && !req_valid && !fill_valid && !fault_valid, "R10 reset state",
              {60'h0, walk_idle, req_valid, fill_valid, fault_valid}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(walk_idle && !req_valid, "R10 idle after release",
              {62'h0, walk_idle, req_valid}, 64'h2);

        // every VPN from the top level
        for (int v = 0; v < (1 << VPN_W); v++) begin
            logic [63:0] r = mix(64'(v) ^ 64'h55);
            do_walk(VPN_W'(v), r[39:0], 0, (v % 7) == 3);
        end
        // lower start levels on a slice of VPNs
        for (int s = 1; s < LEVELS; s++) begin
            for (int v = 0; v < 512; v++) begin
                logic [63:0] r = mix(64'(v * 11 + s) ^ 64'hC3);
                do_walk(VPN_W'(v * 8 + s), r[39:0], s, (v % 5) == 1);
            end
        end
        finish_run();
    end

endmodule